// File: doc/BRIEF.md
# Low-Power SDRAM Clock-Enable State Tracker

This block follows the power state of a mobile SDRAM device from the controller side. On every clock edge it takes the clock-enable level sampled at the previous edge, the level at the current edge, the command code issued at the current edge and a flag that marks a read or write burst in progress. From these it works out the state the device enters. The possible states are all banks idle, active (reading or writing), power-down, self refresh, clock suspend, deep power-down, and a guarded exit window that follows self refresh.

Any combination of state, clock-enable history and command that the device does not define raises a one-cycle illegal flag. The tracked state is left unchanged in that case. A controller uses the "command allowed" output to hold back real commands until the device can accept them. This matters most during the self-refresh exit window, which lasts at least a parameterised number of cycles and must also contain two NOP commands.

Top module: `lpsd_cke_tracker`

## Requirements
- R1: After reset the state output is 0 (all banks idle), the illegal flag is 0 and command-allowed is 1. The clock enable seen at the previous edge is taken as high, so a first edge with CKE low and a NOP enters power-down.
- R2: State codes are 0 idle, 1 active, 2 power-down, 3 self refresh, 4 clock suspend, 5 deep power-down and 6 self-refresh exit guard. Command codes are 0 NOP, 1 INHIBIT, 2 AUTO REFRESH, 3 BURST TERMINATE, 4 READ, 5 WRITE, and 6 or 7 for any other command. In idle or active, an edge with CKE high at both edges moves to active when busy_i is 1 and to idle when it is 0, for any command.
- R3: In idle, an edge with CKE high then low enters state 2 on NOP or INHIBIT, state 3 on AUTO REFRESH and state 5 on BURST TERMINATE.
- R4: In idle, an edge with CKE high then low and any command other than codes 0 to 3 is illegal.
- R5: In active, an edge with CKE high then low enters clock suspend for any command. Clock suspend is kept while CKE stays low, and a low-to-high edge returns the state to active.
- R6: In power-down, self refresh or deep power-down, CKE low at both edges keeps the state for any command. A low-to-high edge with NOP or INHIBIT leaves it: power-down and deep power-down go to idle, and self refresh goes to the guard state 6.
- R7: In power-down, self refresh or deep power-down, a low-to-high edge with any command other than NOP or INHIBIT is illegal.
- R8: The guard state is left for idle on the first edge at which at least TXSR_CYC edges have passed since the exit edge and at least two NOPs (code 0) have been counted. INHIBIT edges advance the cycle count but are not counted as NOPs.
- R9: In the guard state, any command other than NOP or INHIBIT, or CKE low at either edge, is illegal. Such an edge advances neither the cycle count nor the NOP count.
- R10: An illegal edge sets illegal_o for exactly the following cycle and leaves the state unchanged. An edge with CKE low at the previous edge while in idle or active is also illegal.
- R11: cmd_ok_o is 1 exactly when the state is idle or active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock-enable level at this edge |
| cmd_i | input | 3 | Command code issued at this edge |
| busy_i | input | 1 | Read or write burst in progress |
| state_o | output | 3 | Tracked device state |
| illegal_o | output | 1 | Previous edge was an undefined combination |
| cmd_ok_o | output | 1 | Device can accept a real command |

## Verification
Every result of edge n appears on the outputs in the cycle after that edge, because the state, the illegal flag and command-allowed all come from one register stage. The bench changes inputs just after a falling edge, lets one rising edge take them, and samples at the next falling edge. It checks the result of each edge in isolation. In the exit-window scenarios it counts edges one at a time, so the release to idle is checked at the exact edge where it is due, and the edge before it is checked to still be in the guard state.

// File: rtl/lpsd_pkg.sv
package lpsd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_PDN    = 3'd2,
        ST_SREF   = 3'd3,
        ST_SUSP   = 3'd4,
        ST_DPD    = 3'd5,
        ST_GUARD  = 3'd6
    } pstate_e;

    typedef enum logic [2:0] {
        C_NOP   = 3'd0,
        C_INH   = 3'd1,
        C_AREF  = 3'd2,
        C_BTERM = 3'd3,
        C_READ  = 3'd4,
        C_WRITE = 3'd5,
        C_OTHER = 3'd6,
        C_OTH2  = 3'd7
    } cmd_e;
endpackage

// File: rtl/lpsd_decode.sv
module lpsd_decode
    import lpsd_pkg::*;
(
    input  pstate_e st_i,
    input  logic    prev_i,
    input  logic    cur_i,
    input  cmd_e    cmd_i,
    input  logic    busy_i,
    input  logic    finish_i,
    output pstate_e nxt_o,
    output logic    ill_o,
    output logic    load_o,
    output logic    step_o
);
    logic quiet;
    assign quiet = (cmd_i == C_NOP) || (cmd_i == C_INH);

    always_comb begin
        nxt_o  = st_i;
        ill_o  = 1'b0;
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (st_i)
            ST_IDLE, ST_ACTIVE: begin
                if (prev_i && cur_i) begin
                    nxt_o = busy_i ? ST_ACTIVE : ST_IDLE;
                end else if (prev_i && !cur_i) begin
                    if (st_i == ST_ACTIVE) begin
                        nxt_o = ST_SUSP;
                    end else begin
                        case (cmd_i)
                            C_NOP, C_INH: nxt_o = ST_PDN;
                            C_AREF:       nxt_o = ST_SREF;
                            C_BTERM:      nxt_o = ST_DPD;
                            default:      ill_o = 1'b1;
                        endcase
                    end
                end else begin
                    ill_o = 1'b1;
                end
            end
            ST_PDN, ST_SREF, ST_DPD: begin
                if (!prev_i && !cur_i) begin
                    nxt_o = st_i;
                end else if (!prev_i && cur_i && quiet) begin
                    if (st_i == ST_SREF) begin
                        nxt_o  = ST_GUARD;
                        load_o = 1'b1;
                    end else begin
                        nxt_o = ST_IDLE;
                    end
                end else begin
                    ill_o = 1'b1;
                end
            end
            ST_SUSP: begin
                if (!prev_i) begin
                    nxt_o = cur_i ? ST_ACTIVE : ST_SUSP;
                end else begin
                    ill_o = 1'b1;
                end
            end
            ST_GUARD: begin
                if (prev_i && cur_i && quiet) begin
                    step_o = 1'b1;
                    if (finish_i) begin
                        nxt_o = ST_IDLE;
                    end
                end else begin
                    ill_o = 1'b1;
                end
            end
            default: begin
                nxt_o = ST_IDLE;
                ill_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lpsd_exit_guard.sv
module lpsd_exit_guard #(
    parameter int TXSR_CYC = 4,
    parameter int NOP_MIN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    input  logic is_nop_i,
    output logic finish_o
);
    localparam int CW = $clog2(TXSR_CYC + 1);
    localparam int NW = $clog2(NOP_MIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [NW-1:0] nops;
    } gst_t;

    gst_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (load_i) begin
            g_d.cnt  = CW'(TXSR_CYC);
            g_d.nops = '0;
        end else if (step_i) begin
            if (g_q.cnt != '0) g_d.cnt = g_q.cnt - 1'b1;
            if (is_nop_i && (g_q.nops != NW'(NOP_MIN))) g_d.nops = g_q.nops + 1'b1;
        end
    end

    assign finish_o = (g_q.cnt <= CW'(1)) &&
                      ((g_q.nops == NW'(NOP_MIN)) ||
                       (is_nop_i && (g_q.nops == NW'(NOP_MIN - 1))));

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    // R8: the window count never exceeds the loaded length
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= CW'(TXSR_CYC));
    // R9: without a step or load, the counters do not move
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(g_q));
endmodule

// File: rtl/lpsd_cke_tracker.sv
module lpsd_cke_tracker
    import lpsd_pkg::*;
#(
    parameter int TXSR_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       busy_i,
    output logic [2:0] state_o,
    output logic       illegal_o,
    output logic       cmd_ok_o
);
    typedef struct packed {
        pstate_e st;
        logic    cke;
        logic    ill;
    } trk_t;

    trk_t    r_d, r_q;
    pstate_e nxt;
    logic    ill, load, step, finish;
    cmd_e    cmd;

    assign cmd = cmd_e'(cmd_i);

    lpsd_decode u_dec (
        .st_i    (r_q.st),
        .prev_i  (r_q.cke),
        .cur_i   (cke_i),
        .cmd_i   (cmd),
        .busy_i  (busy_i),
        .finish_i(finish),
        .nxt_o   (nxt),
        .ill_o   (ill),
        .load_o  (load),
        .step_o  (step)
    );

    lpsd_exit_guard #(.TXSR_CYC(TXSR_CYC), .NOP_MIN(2)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .is_nop_i(cmd == C_NOP),
        .finish_o(finish)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cke = cke_i;
        r_d.ill = ill;
        r_d.st  = ill ? r_q.st : nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cke <= 1'b1;
            r_q.ill <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.st;
    assign illegal_o = r_q.ill;
    assign cmd_ok_o  = (r_q.st == ST_IDLE) || (r_q.st == ST_ACTIVE);

    // R3: idle with CKE falling and burst terminate enters deep power-down
    a_r3_dpd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && r_q.cke && !cke_i && cmd_i == 3'd3) |=> (state_o == 3'd5));
    // R5: clock suspend with CKE rising returns to active
    a_r5_susp_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SUSP && !r_q.cke && cke_i) |=> (state_o == 3'd1));
    // R6: self refresh never goes straight to idle
    a_r6_sref_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SREF) |=> (state_o != 3'd0));
    // R9: a real command inside the exit window is flagged
    a_r9_guard_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GUARD && cmd_i > 3'd1) |=> (illegal_o && state_o == 3'd6));
    // R10: an illegal edge leaves the state where it was
    a_r10_hold_on_ill: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(state_o));
endmodule

// File: tb/lpsd_cke_tracker_test.sv
`timescale 1ns/1ps
module lpsd_cke_tracker_test;
    localparam int TXSR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic       busy = 1'b0;
    logic [2:0] state;
    logic       ill, ok;
    int         n_run = 0;
    int         n_bad = 0;

    localparam logic [2:0] NOP = 3'd0, INH = 3'd1, AREF = 3'd2, BT = 3'd3,
                           RD = 3'd4, WR = 3'd5, OTH = 3'd6;

    always #10 clk = ~clk;

    lpsd_cke_tracker #(.TXSR_CYC(TXSR)) uut (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cmd_i(cmd), .busy_i(busy),
        .state_o(state), .illegal_o(ill), .cmd_ok_o(ok)
    );

    task automatic tick(input logic k, input logic [2:0] c, input logic b);
        cke = k; cmd = c; busy = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] es, input logic ei, input logic eo);
        n_run++;
        if (state !== es || ill !== ei || ok !== eo) begin
            n_bad++;
            $display("FAIL %s: state/ill/ok = %0d/%0b/%0b expected %0d/%0b/%0b",
                     req, state, ill, ok, es, ei, eo);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset", 3'd0, 1'b0, 1'b1);
        tick(1'b0, NOP, 1'b0); chk("R1 first low edge", 3'd2, 1'b0, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R6 pdn exit", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_busy();
        tick(1'b1, RD, 1'b1);  chk("R2 busy active", 3'd1, 1'b0, 1'b1);
        tick(1'b1, OTH, 1'b1); chk("R2 stay active", 3'd1, 1'b0, 1'b1);
        tick(1'b1, WR, 1'b0);  chk("R2 back idle R11", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_pdn();
        tick(1'b0, INH, 1'b0); chk("R3 pdn entry", 3'd2, 1'b0, 1'b0);
        tick(1'b0, RD, 1'b0);  chk("R6 pdn hold", 3'd2, 1'b0, 1'b0);
        tick(1'b1, INH, 1'b0); chk("R6 pdn exit", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_dpd();
        tick(1'b0, BT, 1'b0);  chk("R3 dpd entry", 3'd5, 1'b0, 1'b0);
        tick(1'b0, AREF, 1'b0); chk("R6 dpd hold", 3'd5, 1'b0, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R6 dpd exit", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_susp();
        tick(1'b1, NOP, 1'b1); chk("R2 active", 3'd1, 1'b0, 1'b1);
        tick(1'b0, OTH, 1'b1); chk("R5 susp entry", 3'd4, 1'b0, 1'b0);
        tick(1'b0, RD, 1'b1);  chk("R5 susp hold", 3'd4, 1'b0, 1'b0);
        tick(1'b1, WR, 1'b1);  chk("R5 susp exit", 3'd1, 1'b0, 1'b1);
        tick(1'b1, NOP, 1'b0); chk("R2 idle", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic sref_in();
        tick(1'b0, AREF, 1'b0); chk("R3 sref entry", 3'd3, 1'b0, 1'b0);
        tick(1'b0, NOP, 1'b0);  chk("R6 sref hold", 3'd3, 1'b0, 1'b0);
        tick(1'b1, NOP, 1'b0);  chk("R6 sref exit to guard R11", 3'd6, 1'b0, 1'b0);
    endtask

    task automatic t_guard_nops();
        sref_in();
        for (int i = 0; i < TXSR - 1; i++) begin
            tick(1'b1, NOP, 1'b0); chk("R8 guard window", 3'd6, 1'b0, 1'b0);
        end
        tick(1'b1, NOP, 1'b0); chk("R8 guard release", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_guard_inh();
        sref_in();
        for (int i = 0; i < TXSR; i++) begin
            tick(1'b1, INH, 1'b0); chk("R8 inhibit not counted", 3'd6, 1'b0, 1'b0);
        end
        tick(1'b1, NOP, 1'b0); chk("R8 one nop only", 3'd6, 1'b0, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R8 second nop release", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_guard_bad();
        sref_in();
        tick(1'b1, RD, 1'b0);  chk("R9 read in guard", 3'd6, 1'b1, 1'b0);
        tick(1'b0, NOP, 1'b0); chk("R9 cke low in guard", 3'd6, 1'b1, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R9 prev low in guard", 3'd6, 1'b1, 1'b0);
        for (int i = 0; i < TXSR - 1; i++) begin
            tick(1'b1, NOP, 1'b0); chk("R9 count held", 3'd6, 1'b0, 1'b0);
        end
        tick(1'b1, NOP, 1'b0); chk("R9 late release", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_idle_bad();
        tick(1'b0, RD, 1'b0);  chk("R4 read on cke fall", 3'd0, 1'b1, 1'b1);
        tick(1'b1, NOP, 1'b0); chk("R10 prev low in idle", 3'd0, 1'b1, 1'b1);
        tick(1'b1, NOP, 1'b0); chk("R10 flag one cycle", 3'd0, 1'b0, 1'b1);
        tick(1'b0, OTH, 1'b0); chk("R4 other on cke fall", 3'd0, 1'b1, 1'b1);
        tick(1'b1, NOP, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R10 recovered", 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_exit_bad();
        tick(1'b0, NOP, 1'b0); chk("R3 pdn entry", 3'd2, 1'b0, 1'b0);
        tick(1'b1, WR, 1'b0);  chk("R7 write on exit", 3'd2, 1'b1, 1'b0);
        tick(1'b0, NOP, 1'b0); chk("R7 prev high in pdn", 3'd2, 1'b1, 1'b0);
        tick(1'b0, NOP, 1'b0); chk("R7 hold after", 3'd2, 1'b0, 1'b0);
        tick(1'b1, AREF, 1'b0); chk("R7 aref on exit", 3'd2, 1'b1, 1'b0);
        tick(1'b0, NOP, 1'b0);
        tick(1'b0, NOP, 1'b0);
        tick(1'b1, NOP, 1'b0); chk("R7 clean exit", 3'd0, 1'b0, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy();
        t_pdn();
        t_dpd();
        t_susp();
        t_guard_nops();
        t_guard_inh();
        t_guard_bad();
        t_idle_bad();
        t_exit_bad();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule